// File: doc/BRIEF.md
# Two-Operand Tree Carry-Lookahead Adder

A purely combinational adder for two equal-width unsigned or two's-complement operands plus a single carry input. Every bit first forms a generate term (both operand bits set) and a propagate term (operand bits differ). A binary tree of two-input cells then merges neighbouring ranges into range-wide generate and propagate pairs, one tree level for every doubling of the range. A second pass runs back down the same tree, handing each upper half the carry out of its lower half. Each sum bit is its propagate term XORed with the carry that reaches it.

The depth grows with the logarithm of the width instead of with the width itself. The range-wide generate and propagate pair for the whole operand is brought out, so a wider adder can place several of these blocks under a further lookahead level. The width is a power-of-two parameter, 8 by default.

Top module: `cla_tree_adder`

## Requirements
- R1: `sum` equals the low WIDTH bits of `op_a + op_b + carry_in`, with the operands taken as unsigned.
- R2: `carry_out` equals bit WIDTH of the full-width total `op_a + op_b + carry_in`.
- R3: `grp_prop` is 1 exactly when every bit position has differing operand bits, that is when `op_b` equals the bitwise complement of `op_a`.
- R4: `grp_gen` is 1 exactly when `op_a + op_b` with no carry input is at least 2^WIDTH.
- R5: When `grp_prop` is 1, `carry_out` equals `carry_in` and every bit of `sum` equals the inverse of `carry_in`.
- R6: `grp_gen` and `grp_prop` are never both 1.
- R7: Every output depends only on the present inputs: the result for one input pattern is the same no matter which pattern came before it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | WIDTH | First operand |
| op_b | input | WIDTH | Second operand |
| carry_in | input | 1 | Carry into bit 0 |
| sum | output | WIDTH | Low WIDTH bits of the total |
| carry_out | output | 1 | Carry out of the top bit |
| grp_gen | output | 1 | The whole operand range generates a carry on its own |
| grp_prop | output | 1 | The whole operand range passes an incoming carry through |

## Verification
The block holds no state, so a wrong cell in the tree shows at the ports in the same cycle as the input pattern that uses it. A broken merge on the way up alters `grp_gen` or `grp_prop`, and also every carry that relies on that range. A broken carry on the way down flips the sum bit it feeds, and often the bits above it. Only the operand pairs that carry across the faulty node expose the fault, so the bench applies every operand pair with both carry-input values and checks each one in its own clock cycle.

// File: rtl/cla_tree_adder.sv
module cla_tree_adder #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  input  logic             carry_in,
  output logic [WIDTH-1:0] sum,
  output logic             carry_out,
  output logic             grp_gen,
  output logic             grp_prop
);
  localparam int LEVELS = $clog2(WIDTH);

  for (genvar l = 0; l <= LEVELS; l++) begin : lvl
    localparam int NODES = WIDTH >> l;
    logic [NODES-1:0] g;
    logic [NODES-1:0] p;
    logic [NODES-1:0] c;

    if (l == 0) begin : leaf
      assign g = op_a & op_b;
      assign p = op_a ^ op_b;
    end else begin : merge
      for (genvar k = 0; k < NODES; k++) begin : node
        assign g[k] = lvl[l-1].g[2*k+1] | (lvl[l-1].p[2*k+1] & lvl[l-1].g[2*k]);
        assign p[k] = lvl[l-1].p[2*k+1] & lvl[l-1].p[2*k];
      end
    end

    if (l == LEVELS) begin : root
      assign c[0] = carry_in;
    end else begin : spread
      for (genvar k = 0; k < NODES; k++) begin : node
        if (k % 2 == 0) begin : lo
          assign c[k] = lvl[l+1].c[k/2];
        end else begin : hi
          assign c[k] = g[k-1] | (p[k-1] & lvl[l+1].c[k/2]);
        end
      end
    end
  end

  assign sum       = lvl[0].p ^ lvl[0].c;
  assign grp_gen   = lvl[LEVELS].g[0];
  assign grp_prop  = lvl[LEVELS].p[0];
  assign carry_out = grp_gen | (grp_prop & carry_in);
endmodule

// File: rtl/cla_tree_adder_chk.sv
module cla_tree_adder_chk #(
  parameter int WIDTH = 8
) (
  input logic [WIDTH-1:0] op_a,
  input logic [WIDTH-1:0] op_b,
  input logic             carry_in,
  input logic [WIDTH-1:0] sum,
  input logic             carry_out,
  input logic             grp_gen,
  input logic             grp_prop
);
  logic [WIDTH:0] ref_total;
  logic [WIDTH:0] ref_nocin;

  always_comb begin
    ref_nocin = {1'b0, op_a} + {1'b0, op_b};
    ref_total = ref_nocin + {{WIDTH{1'b0}}, carry_in};
  end

  always_comb begin
    AST_SUM_BITS: assert (sum == ref_total[WIDTH-1:0]); // R1
    AST_CARRY_OUT: assert (carry_out == ref_total[WIDTH]); // R2
    AST_RANGE_PROP: assert (grp_prop == (op_b == ~op_a)); // R3
    AST_RANGE_GEN: assert (grp_gen == ref_nocin[WIDTH]); // R4
    AST_PASS_THROUGH: assert (!grp_prop || (carry_out == carry_in && sum == {WIDTH{~carry_in}})); // R5
    AST_GEN_PROP_EXCL: assert (!(grp_gen && grp_prop)); // R6
  end
endmodule

bind cla_tree_adder cla_tree_adder_chk #(.WIDTH(WIDTH)) chk_i (
  .op_a(op_a),
  .op_b(op_b),
  .carry_in(carry_in),
  .sum(sum),
  .carry_out(carry_out),
  .grp_gen(grp_gen),
  .grp_prop(grp_prop)
);

// File: tb/cla_tree_adder_tb_top.sv
module cla_tree_adder_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8;
  localparam int SPAN = 1 << W;
  localparam int WATCHDOG = 200000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [W-1:0] op_a = '0;
  logic [W-1:0] op_b = '0;
  logic carry_in = 1'b0;
  logic [W-1:0] sum;
  logic carry_out, grp_gen, grp_prop;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit done = 0;

  cla_tree_adder #(.WIDTH(W)) dut_i (
    .op_a(op_a), .op_b(op_b), .carry_in(carry_in),
    .sum(sum), .carry_out(carry_out), .grp_gen(grp_gen), .grp_prop(grp_prop)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input int actual, input int expected);
    checks++;
    if (actual != expected) begin
      failures++;
      $display("FAIL %s a=%0d b=%0d cin=%0d actual=%0d expected=%0d",
               req, op_a, op_b, carry_in, actual, expected);
    end
  endtask

  task automatic apply_and_check(input int a, input int b, input int cin);
    int total, nocin, exp_prop;
    @(posedge clk);
    #1;
    op_a = W'(a);
    op_b = W'(b);
    carry_in = cin[0];
    @(negedge clk);
    total = a + b + cin;
    nocin = a + b;
    exp_prop = ((a ^ b) == SPAN - 1) ? 1 : 0;
    check("R1", int'(sum), total % SPAN);
    check("R2", int'(carry_out), total / SPAN);
    check("R3", int'(grp_prop), exp_prop);
    check("R4", int'(grp_gen), (nocin >= SPAN) ? 1 : 0);
    check("R6", int'(grp_gen & grp_prop), 0);
    if (exp_prop == 1) begin
      check("R5", int'(carry_out), cin);
      check("R5", int'(sum), (cin == 1) ? 0 : SPAN - 1);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (!done && cycles >= WATCHDOG) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=<%0d", cycles, WATCHDOG);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // idle state with all inputs low: R1 R2 R3 R4
    check("R1", int'(sum), 0);
    check("R2", int'(carry_out), 0);
    check("R3", int'(grp_prop), 0);
    check("R4", int'(grp_gen), 0);

    // boundary patterns
    apply_and_check(SPAN - 1, 1, 0);
    apply_and_check(SPAN - 1, 0, 1);
    apply_and_check(SPAN - 1, SPAN - 1, 1);
    apply_and_check(8'h55, 8'hAA, 0);
    apply_and_check(8'h55, 8'hAA, 1);

    // R7: same pattern after different predecessors must match
    apply_and_check(8'hF0, 8'h0F, 1);
    apply_and_check(8'h3C, 8'h44, 0);
    apply_and_check(8'hF0, 8'h0F, 1);

    // exhaustive sweep, both carry-in values
    for (int cin = 0; cin < 2; cin++)
      for (int a = 0; a < SPAN; a++)
        for (int b = 0; b < SPAN; b++)
          apply_and_check(a, b, cin);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule